// File: doc/BRIEF.md
# Pipelined AES-128 Block Encryptor

This block encrypts 128-bit blocks with AES-128. The ten cipher rounds are laid out in space, one register stage per round, so it can take a new plaintext block and key on every clock. It returns one ciphertext block on every clock once the pipeline is full. Up to ten blocks are in flight at once, each in a different round. Each block brings its own 128-bit key. The round keys are derived stage by stage from that key and travel with the data, so neighbouring blocks may use unrelated keys.

The first key addition (plaintext XOR key) is combinational ahead of the first stage. Stages one to nine each perform byte substitution, row rotation, column mixing and the round-key addition. The last stage leaves out the column mixing. Byte substitution reads a 256-entry constant table, which is computed from the field inverse and the affine map when the design is built. A valid flag runs alongside the data, so idle cycles can be mixed freely between blocks.

Top module: `aes128_pipe_enc`

## Requirements
- R1: A synchronous active-high `rst` clears every in-flight valid flag, so `out_valid` is 0 on every cycle after a reset edge until a block presented after the reset has completed ten stages. Blocks already inside the pipeline are dropped, and so is a block presented on the reset edge.
- R2: A block sampled with `in_valid`=1 on rising edge n appears on `out_data` with `out_valid`=1 after rising edge n+9, which is exactly ten clock periods after it was driven. It appears neither earlier nor later.
- R3: With key 000102030405060708090A0B0C0D0E0F and plaintext 00112233445566778899AABBCCDDEEFF, the output is 69C4E0D86A7B0430D8CDB78070B4C55A.
- R4: Blocks presented on consecutive clocks leave on consecutive clocks in the same order, each with its own correct ciphertext. This gives one result per clock.
- R5: Each block is encrypted under the key presented with it, even when the key changes on every clock.
- R6: A cycle with `in_valid`=0 produces a cycle with `out_valid`=0 exactly ten clock periods later. The data and key presented with it have no effect on any valid result.
- R7: Byte order is big-endian. Bits 127:120 are byte 0, and bytes fill the 4x4 state column by column (byte index = row + 4*column). This applies to the data, the key and the result.
- R8: The key schedule applies the round constants 01,02,04,08,10,20,40,80,1B,36 in rounds one to ten. With key 2B7E151628AED2A6ABF7158809CF4F3C and plaintext 3243F6A8885A308D313198A2E0370734, the output is 3925841D02DC09FBDC118597196A0B32.
- R9: The substitution table agrees with the standard byte map for every byte value reached by the pseudo-random blocks and keys.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid flags |
| in_valid | input | 1 | A block and key are presented this cycle |
| in_data | input | 128 | Plaintext block, byte 0 in bits 127:120 |
| in_key | input | 128 | Cipher key for this block, byte 0 in bits 127:120 |
| out_valid | output | 1 | `out_data` holds a finished ciphertext |
| out_data | output | 128 | Ciphertext block, byte 0 in bits 127:120 |

## Verification
Every result is due exactly ten clock periods after its inputs were driven. The bench drives inputs on falling edges. On each falling edge it compares the outputs with the entry it drove ten falling edges earlier: valid flag, and ciphertext when that entry was valid. An early, late or missing result therefore fails in the very cycle it goes wrong. Expected ciphertexts come from a behavioural cipher in the bench. That model builds its own substitution table by searching for field inverses. After a reset, the bench checks the output valid on each of the following twelve falling edges.

// File: rtl/aes_enc_pkg.sv
package aes_enc_pkg;

    localparam int BLK_W   = 128;
    localparam int BYTE_W  = 8;
    localparam int NBYTES  = BLK_W / BYTE_W;
    localparam int NROWS   = 4;
    localparam int NCOLS   = NBYTES / NROWS;
    localparam int WORD_W  = BYTE_W * NROWS;
    localparam int NROUNDS = 10;
    localparam int SB_SIZE = 1 << BYTE_W;

    typedef logic [BLK_W-1:0]  blk_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic vld;
        blk_t state;
        blk_t rkey;
    } stage_t;

    function automatic byte_t xtime(input byte_t b);
        return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t p;
        byte_t aa;
        p  = '0;
        aa = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) p = p ^ aa;
            aa = xtime(aa);
        end
        return p;
    endfunction

    function automatic byte_t rotl8(input byte_t v, input int n);
        return byte_t'((v << n) | (v >> (BYTE_W - n)));
    endfunction

    // field inverse as x^254 = x^2 * x^4 * ... * x^128, then the affine map
    function automatic byte_t sbox_calc(input byte_t x);
        byte_t sq;
        byte_t inv;
        sq  = x;
        inv = 8'h01;
        for (int k = 1; k < BYTE_W; k++) begin
            sq  = gf_mul(sq, sq);
            inv = gf_mul(inv, sq);
        end
        return inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3)
                   ^ rotl8(inv, 4) ^ 8'h63;
    endfunction

    function automatic logic [SB_SIZE*BYTE_W-1:0] build_sbox();
        logic [SB_SIZE*BYTE_W-1:0] t;
        t = '0;
        for (int i = 0; i < SB_SIZE; i++)
            t[i*BYTE_W +: BYTE_W] = sbox_calc(byte_t'(i));
        return t;
    endfunction

    localparam logic [SB_SIZE*BYTE_W-1:0] SBOX_ROM = build_sbox();

    function automatic byte_t sub_byte(input byte_t a);
        return SBOX_ROM[{a, 3'b000} +: BYTE_W];
    endfunction

    function automatic byte_t rcon_of(input int rnd);
        byte_t v;
        v = 8'h01;
        for (int i = 1; i < rnd; i++) v = xtime(v);
        return v;
    endfunction

endpackage

// File: rtl/aes_key_step.sv
module aes_key_step
    import aes_enc_pkg::*;
#(
    parameter logic [7:0] RCON = 8'h01
) (
    input  blk_t key_i,
    output blk_t key_o
);

    logic [WORD_W-1:0] w_in  [NROWS];
    logic [WORD_W-1:0] w_out [NROWS];
    logic [WORD_W-1:0] rot_w;
    logic [WORD_W-1:0] mix_w;

    always_comb begin
        for (int j = 0; j < NROWS; j++)
            w_in[j] = key_i[BLK_W-1-WORD_W*j -: WORD_W];
        rot_w = {w_in[NROWS-1][WORD_W-BYTE_W-1:0], w_in[NROWS-1][WORD_W-1 -: BYTE_W]};
        for (int b = 0; b < NROWS; b++)
            mix_w[b*BYTE_W +: BYTE_W] = sub_byte(rot_w[b*BYTE_W +: BYTE_W]);
        mix_w = mix_w ^ {RCON, {(WORD_W-BYTE_W){1'b0}}};
        w_out[0] = w_in[0] ^ mix_w;
        for (int j = 1; j < NROWS; j++)
            w_out[j] = w_in[j] ^ w_out[j-1];
        for (int j = 0; j < NROWS; j++)
            key_o[BLK_W-1-WORD_W*j -: WORD_W] = w_out[j];
    end

endmodule

// File: rtl/aes_round.sv
module aes_round
    import aes_enc_pkg::*;
#(
    parameter bit FINAL = 1'b0
) (
    input  blk_t state_i,
    input  blk_t rkey_i,
    output blk_t state_o
);

    byte_t sub_b   [NBYTES];
    byte_t shift_b [NBYTES];
    byte_t mix_b   [NBYTES];

    always_comb begin
        for (int b = 0; b < NBYTES; b++)
            sub_b[b] = sub_byte(state_i[BLK_W-1-BYTE_W*b -: BYTE_W]);
        for (int c = 0; c < NCOLS; c++)
            for (int r = 0; r < NROWS; r++)
                shift_b[r + NROWS*c] = sub_b[r + NROWS*((c + r) % NCOLS)];
    end

    if (FINAL) begin : g_nomix
        always_comb begin
            for (int b = 0; b < NBYTES; b++) mix_b[b] = shift_b[b];
        end
    end else begin : g_mix
        always_comb begin
            for (int c = 0; c < NCOLS; c++) begin
                mix_b[NROWS*c+0] = xtime(shift_b[NROWS*c+0]) ^ xtime(shift_b[NROWS*c+1])
                                 ^ shift_b[NROWS*c+1] ^ shift_b[NROWS*c+2] ^ shift_b[NROWS*c+3];
                mix_b[NROWS*c+1] = shift_b[NROWS*c+0] ^ xtime(shift_b[NROWS*c+1])
                                 ^ xtime(shift_b[NROWS*c+2]) ^ shift_b[NROWS*c+2] ^ shift_b[NROWS*c+3];
                mix_b[NROWS*c+2] = shift_b[NROWS*c+0] ^ shift_b[NROWS*c+1]
                                 ^ xtime(shift_b[NROWS*c+2]) ^ xtime(shift_b[NROWS*c+3]) ^ shift_b[NROWS*c+3];
                mix_b[NROWS*c+3] = xtime(shift_b[NROWS*c+0]) ^ shift_b[NROWS*c+0]
                                 ^ shift_b[NROWS*c+1] ^ shift_b[NROWS*c+2] ^ xtime(shift_b[NROWS*c+3]);
            end
        end
    end

    always_comb begin
        for (int b = 0; b < NBYTES; b++)
            state_o[BLK_W-1-BYTE_W*b -: BYTE_W] = mix_b[b] ^ rkey_i[BLK_W-1-BYTE_W*b -: BYTE_W];
    end

endmodule

// File: rtl/aes128_pipe_enc.sv
module aes128_pipe_enc
    import aes_enc_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [127:0] in_data,
    input  logic [127:0] in_key,
    output logic         out_valid,
    output logic [127:0] out_data
);

    stage_t st_d [NROUNDS];
    stage_t st_q [NROUNDS];

    blk_t src_state [NROUNDS];
    blk_t src_key   [NROUNDS];
    blk_t nxt_state [NROUNDS];
    blk_t nxt_key   [NROUNDS];

    for (genvar g = 0; g < NROUNDS; g++) begin : g_stage
        localparam logic [7:0] RC = rcon_of(g + 1);

        if (g == 0) begin : g_head
            assign src_state[g] = in_data ^ in_key;
            assign src_key[g]   = in_key;
        end else begin : g_body
            assign src_state[g] = st_q[g-1].state;
            assign src_key[g]   = st_q[g-1].rkey;
        end

        aes_key_step #(.RCON(RC)) u_ks (
            .key_i (src_key[g]),
            .key_o (nxt_key[g])
        );

        aes_round #(.FINAL(g == NROUNDS-1)) u_rnd (
            .state_i (src_state[g]),
            .rkey_i  (nxt_key[g]),
            .state_o (nxt_state[g])
        );
    end

    always_comb begin
        for (int i = 0; i < NROUNDS; i++) begin
            st_d[i].vld   = (i == 0) ? in_valid : st_q[i-1].vld;
            st_d[i].state = nxt_state[i];
            st_d[i].rkey  = nxt_key[i];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NROUNDS; i++) begin
            if (rst) st_q[i].vld <= 1'b0;
            else     st_q[i].vld <= st_d[i].vld;
            st_q[i].state <= st_d[i].state;
            st_q[i].rkey  <= st_d[i].rkey;
        end
    end

    assign out_valid = st_q[NROUNDS-1].vld;
    assign out_data  = st_q[NROUNDS-1].state;

endmodule

// File: rtl/aes128_pipe_enc_chk.sv
module aes128_pipe_enc_chk
    import aes_enc_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic out_valid
);

    localparam int CW = $clog2(NROUNDS + 1) + 1;
    localparam logic [CW-1:0] LAT = CW'(NROUNDS);

    logic [CW-1:0] live_q;
    logic [CW-1:0] busy_q;
    logic [CW-1:0] idle_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
            busy_q <= '0;
            idle_q <= '0;
        end else begin
            if (live_q != LAT) live_q <= live_q + 1'b1;
            busy_q <= in_valid ? ((busy_q != LAT) ? busy_q + 1'b1 : busy_q) : '0;
            idle_q <= in_valid ? '0 : ((idle_q != LAT) ? idle_q + 1'b1 : idle_q);
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !out_valid); // R1

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (live_q == LAT) |-> (out_valid == $past(in_valid, 10))); // R2

    AST_FULL_STREAM: assert property (@(posedge clk) disable iff (rst)
        (busy_q == LAT) |-> out_valid); // R4

    AST_IDLE_DRAINS: assert property (@(posedge clk) disable iff (rst)
        (idle_q == LAT) |-> !out_valid); // R6

endmodule

bind aes128_pipe_enc aes128_pipe_enc_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid)
);

// File: tb/aes128_pipe_enc_tb.sv
`timescale 1ns/1ps
module aes128_pipe_enc_tb;

    localparam int LAT  = 10;
    localparam int MAXN = 64;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] in_data = '0;
    logic [127:0] in_key = '0;
    logic         out_valid;
    logic [127:0] out_data;

    int checks = 0;
    int errors = 0;

    logic [7:0]   sbt [256];
    logic [31:0]  seed = 32'h1234_5678;
    logic [127:0] pt_a  [MAXN];
    logic [127:0] key_a [MAXN];
    logic [127:0] exp_a [MAXN];
    bit           v_a   [MAXN];

    aes128_pipe_enc u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_key(in_key), .out_valid(out_valid), .out_data(out_data)
    );

    always #2 clk = ~clk;

    function automatic logic [7:0] m2(input logic [7:0] b);
        return (b << 1) ^ (b[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = 0;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= a;
            a = m2(a);
        end
        return r;
    endfunction

    function automatic logic [31:0] nxt32();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    function automatic logic [127:0] rnd128();
        return {nxt32(), nxt32(), nxt32(), nxt32()};
    endfunction

    function automatic logic [127:0] ref_enc(input logic [127:0] pt, input logic [127:0] key);
        logic [31:0]  w [44];
        logic [7:0]   s [16];
        logic [7:0]   t [16];
        logic [7:0]   rc = 8'h01;
        logic [31:0]  tw;
        logic [127:0] res;
        for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            tw = w[i-1];
            if (i % 4 == 0) begin
                tw = {tw[23:0], tw[31:24]};
                tw = {sbt[tw[31:24]] ^ rc, sbt[tw[23:16]], sbt[tw[15:8]], sbt[tw[7:0]]};
                rc = m2(rc);
            end
            w[i] = w[i-4] ^ tw;
        end
        for (int b = 0; b < 16; b++) s[b] = pt[127-8*b -: 8] ^ w[b/4][31-8*(b%4) -: 8];
        for (int rd = 1; rd <= 10; rd++) begin
            for (int b = 0; b < 16; b++) s[b] = sbt[s[b]];
            for (int c = 0; c < 4; c++)
                for (int r = 0; r < 4; r++) t[r+4*c] = s[r+4*((c+r)%4)];
            for (int c = 0; c < 4; c++) begin
                if (rd != 10) begin
                    s[4*c+0] = gm(t[4*c],2) ^ gm(t[4*c+1],3) ^ t[4*c+2] ^ t[4*c+3];
                    s[4*c+1] = t[4*c] ^ gm(t[4*c+1],2) ^ gm(t[4*c+2],3) ^ t[4*c+3];
                    s[4*c+2] = t[4*c] ^ t[4*c+1] ^ gm(t[4*c+2],2) ^ gm(t[4*c+3],3);
                    s[4*c+3] = gm(t[4*c],3) ^ t[4*c+1] ^ t[4*c+2] ^ gm(t[4*c+3],2);
                end else begin
                    for (int r = 0; r < 4; r++) s[4*c+r] = t[4*c+r];
                end
            end
            for (int b = 0; b < 16; b++) s[b] ^= w[4*rd + b/4][31-8*(b%4) -: 8];
        end
        for (int b = 0; b < 16; b++) res[127-8*b -: 8] = s[b];
        return res;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // drive entries 0..n-1 then LAT idle cycles; every falling edge checks the
    // outputs against the entry driven LAT falling edges earlier
    task automatic run_stream(input int n, input string tag);
        for (int i = 0; i < n; i++) exp_a[i] = ref_enc(pt_a[i], key_a[i]);
        for (int c = 0; c < n + LAT; c++) begin
            @(negedge clk);
            if (c >= LAT) begin
                chk(out_valid == v_a[c-LAT], tag, "out_valid", 128'(out_valid), 128'(v_a[c-LAT]));
                if (v_a[c-LAT])
                    chk(out_data == exp_a[c-LAT], tag, "out_data", out_data, exp_a[c-LAT]);
            end else begin
                chk(out_valid == 1'b0, tag, "early out_valid", 128'(out_valid), 128'd0);
            end
            if (c < n) begin
                in_valid = v_a[c];
                in_data  = pt_a[c];
                in_key   = key_a[c];
            end else begin
                in_valid = 1'b0;
                in_data  = rnd128();
                in_key   = rnd128();
            end
        end
    endtask

    task automatic load_kat(input int i, input logic [127:0] p, input logic [127:0] k);
        pt_a[i] = p; key_a[i] = k; v_a[i] = 1'b1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [127:0] k;
        // bench S-box: inverse by exhaustive search, then affine map
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv = 0;
            for (int y = 1; y < 256; y++)
                if (x != 0 && gm(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            sbt[x] = inv ^ {inv[6:0],inv[7]} ^ {inv[5:0],inv[7:6]}
                   ^ {inv[4:0],inv[7:5]} ^ {inv[3:0],inv[7:4]} ^ 8'h63;
        end

        // R1: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R1", "out_valid after reset", 128'(out_valid), 128'd0);
        end

        // R2 R3 R7: single block, standard vector, exact arrival cycle
        load_kat(0, 128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f);
        chk(ref_enc(pt_a[0], key_a[0]) == 128'h69c4e0d86a7b0430d8cdb78070b4c55a,
            "R3", "bench model", ref_enc(pt_a[0], key_a[0]), 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
        run_stream(1, "R3");

        // R8: second standard vector
        load_kat(0, 128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c);
        run_stream(1, "R8");
        chk(ref_enc(pt_a[0], key_a[0]) == 128'h3925841d02dc09fbdc118597196a0b32,
            "R8", "bench model", ref_enc(pt_a[0], key_a[0]), 128'h3925841d02dc09fbdc118597196a0b32);

        // R4 R9: back-to-back blocks under one key
        k = rnd128();
        for (int i = 0; i < 40; i++) begin pt_a[i] = rnd128(); key_a[i] = k; v_a[i] = 1'b1; end
        run_stream(40, "R4");

        // R5: key changes on every block
        for (int i = 0; i < 40; i++) begin pt_a[i] = rnd128(); key_a[i] = rnd128(); v_a[i] = 1'b1; end
        run_stream(40, "R5");

        // R6: random idle slots carrying junk data and keys
        for (int i = 0; i < MAXN; i++) begin
            pt_a[i] = rnd128(); key_a[i] = rnd128(); v_a[i] = nxt32() % 3 != 0;
        end
        v_a[0] = 1'b0; v_a[1] = 1'b1; v_a[2] = 1'b0;
        run_stream(MAXN, "R6");

        // R1: reset while the pipeline holds blocks
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = rnd128(); in_key = rnd128();
        end
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R1", "out_valid after mid-stream reset", 128'(out_valid), 128'd0);
        end

        // R7: recovery and byte order after reset
        load_kat(0, 128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f);
        load_kat(1, 128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c);
        run_stream(2, "R7");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule